// File: doc/BRIEF.md
# Microcoded Bus Pattern Sequencer

This block drives the control lines of an external bus from a small pattern memory of control words. A routine is a run of consecutive words that starts at an index named by a request. In each bus clock cycle the block runs one word. That word sets the general-purpose output lines, raises transfer-acknowledge, steps an address counter, and chooses when read data is captured.

A word can run for up to four consecutive cycles. A pair of loop markers, together with a loop count taken when the routine starts, can replay a stretch of words. When a routine ends, a request that is already waiting starts at once, with no idle cycle in between. With nothing waiting, the lines fall back to all-high. Pattern words are loaded through a write port that only works while no routine is running.

Top module: `bus_pattern_seq`

## Requirements
- R1: After reset the lines are all high, `xfer_ack`, `busy` and `err` are 0, and `bus_addr` and `data_q` are 0.
- R2: A request taken while idle runs the word at `req_idx` in the cycle after the request edge. In that cycle `busy` is 1 and `bus_addr` equals `req_addr`.
- R3: Control word layout (LSB first): bit0 end-of-routine, bit1 acknowledge, bit2 address step, bit3 mid-cycle sample, bits5:4 repeat, bit6 loop-start mark, bit7 loop-end mark. Line i is taken from bit 8+i.
- R4: A word with repeat value n runs for n+1 consecutive cycles. Its lines stay the same in all of them, and if its acknowledge bit is set, `xfer_ack` is 1 in every one of them.
- R5: `bus_addr` goes up by one at the end of each cycle in which the running word has its address-step bit set, repeated cycles included.
- R6: The index of the last word run with a loop-start mark is remembered. Once a loop-end word has finished all its runs, control jumps back to that index if the loop count is nonzero, and the count goes down by one. The count is loaded from `loop_count` when the routine starts.
- R7: In the cycle after an end-of-routine word, with no request waiting, the lines are all high, `xfer_ack` is 0 and `busy` is 0.
- R8: Two kinds of request chain into the next routine: one accepted while busy, or one that arrives during the end-of-routine cycle. Its first word runs in the cycle right after the end word, and `bus_addr` is loaded with its address. A request that arrives while another is already waiting is dropped.
- R9: A word with the end bit set and a nonzero repeat value runs only once. From the next cycle `err` reads 1, and it stays 1 until reset.
- R10: In a read routine, a word with acknowledge set and no mid-cycle selection copies `data_in` as it stands at the rising edge that ends the cycle. The value appears on `data_q` after that edge.
- R11: When `mode_dly` is 1 and the word's mid-cycle bit is set, the value copied is the `data_in` seen at the falling edge in the middle of the cycle.
- R12: A write while `busy` is 1 changes no pattern word. A write while idle takes effect for routines started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Routine request, one-cycle pulse |
| req_idx | input | 6 | First word index of the requested routine |
| req_addr | input | 16 | Start address for the requested routine |
| req_rd | input | 1 | Requested routine is a read |
| loop_count | input | 4 | Loop count loaded at routine start |
| mode_dly | input | 1 | Allows mid-cycle data capture |
| wr_en | input | 1 | Pattern write strobe |
| wr_idx | input | 6 | Pattern write index |
| wr_word | input | 14 | Pattern word to store |
| data_in | input | 16 | External read data |
| bus_lines | output | 6 | General-purpose bus lines |
| xfer_ack | output | 1 | Transfer acknowledge |
| bus_addr | output | 16 | Address counter |
| data_q | output | 16 | Captured read data |
| busy | output | 1 | A routine is running |
| err | output | 1 | Sticky illegal-word flag |

## Verification
Lines, `xfer_ack` and `busy` follow the current word through logic alone. They change one edge after the request or after the previous word, so the bench reads them two nanoseconds after each rising edge. `bus_addr` and `err` are registers that move on the edge that closes the cycle responsible for them, so they are checked in the following cycle. Mid-cycle capture is tested by changing `data_in` between the falling edge and the closing rising edge. `data_q` is then read after that rising edge, and its value shows which of the two was sampled.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
   localparam int CTRL_BITS = 8;
   localparam int F_END     = 0;
   localparam int F_ACK     = 1;
   localparam int F_STEP    = 2;
   localparam int F_HALF    = 3;
   localparam int F_REP_LO  = 4;
   localparam int F_LSTART  = 6;
   localparam int F_LEND    = 7;
   localparam int F_LINES   = 8;
endpackage

// File: rtl/bus_seq_pram.sv
module bus_seq_pram #(
   parameter int DEPTH = 64,
   parameter int WW    = 14,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          lock,
   input  logic          we,
   input  logic [IW-1:0] wi,
   input  logic [WW-1:0] wd,
   input  logic [IW-1:0] ri,
   output logic [WW-1:0] rd
);
   generate
      if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
         $error("bus_seq_pram: DEPTH out of range");
      end
   endgenerate

   logic [WW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && !lock) mem[wi] <= wd;
   end

   assign rd = mem[ri];

   assert_locked_write_R12: assert property (@(posedge clk)
      (we && lock) |=> mem[$past(wi)] == $past(mem[wi]));
endmodule

// File: rtl/bus_seq_addr.sv
module bus_seq_addr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_val,
   input  logic          inc,
   output logic [AW-1:0] q
);
   generate
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("bus_seq_addr: AW out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= ld_val;
      else if (inc)  q <= q + 1'b1;
   end

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/bus_seq_sample.sv
module bus_seq_sample #(
   parameter int DW      = 16,
   parameter bit HALF_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic          dly,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   logic [DW-1:0] mid_q;
   logic          use_mid;

   generate
      if (HALF_EN) begin : g_mid
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)          mid_q <= '0;
            else if (cap && dly) mid_q <= d;
         end
         assign use_mid = dly;
      end else begin : g_rise_only
         assign mid_q   = '0;
         assign use_mid = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= use_mid ? mid_q : d;
   end

   assert_rise_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !dly) |=> q == $past(d));
endmodule

// File: rtl/bus_pattern_seq.sv
module bus_pattern_seq
   import bus_seq_pkg::*;
#(
   parameter int LINES   = 6,
   parameter int DEPTH   = 64,
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int LCW     = 4,
   parameter bit HALF_EN = 1'b1,
   localparam int IW     = $clog2(DEPTH),
   localparam int WW     = CTRL_BITS + LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [IW-1:0]    req_idx,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_rd,
   input  logic [LCW-1:0]   loop_count,
   input  logic             mode_dly,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [WW-1:0]    wr_word,
   input  logic [DW-1:0]    data_in,
   output logic [LINES-1:0] bus_lines,
   output logic             xfer_ack,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    data_q,
   output logic             busy,
   output logic             err
);
   generate
      if (LINES < 1 || LINES > 24) begin : g_bad_lines
         $error("bus_pattern_seq: LINES out of range");
      end
      if (LCW < 1) begin : g_bad_lcw
         $error("bus_pattern_seq: LCW must be positive");
      end
   endgenerate

   logic            active, rd_mode, pend_v, pend_rd;
   logic [IW-1:0]   cur, lp_idx, pend_idx;
   logic [AW-1:0]   pend_addr;
   logic [1:0]      rep_cnt;
   logic [LCW-1:0]  lp_cnt;
   logic [WW-1:0]   word;

   logic            w_end, w_ack, w_step, w_half, w_ls, w_le;
   logic [1:0]      w_rep, rep_eff;
   logic            last_rep, adv, end_now, use_pend, use_req, launch;
   logic [IW-1:0]   s_idx;
   logic [AW-1:0]   s_addr;
   logic            s_rd;

   bus_seq_pram #(.DEPTH(DEPTH), .WW(WW)) u_pram (
      .clk(clk), .lock(active), .we(wr_en), .wi(wr_idx), .wd(wr_word),
      .ri(cur), .rd(word));

   assign w_end  = word[F_END];
   assign w_ack  = word[F_ACK];
   assign w_step = word[F_STEP];
   assign w_half = word[F_HALF];
   assign w_rep  = word[F_REP_LO +: 2];
   assign w_ls   = word[F_LSTART];
   assign w_le   = word[F_LEND];

   assign rep_eff  = w_end ? 2'd0 : w_rep;
   assign last_rep = (rep_cnt == rep_eff);
   assign adv      = active && last_rep;
   assign end_now  = adv && w_end;
   assign use_pend = end_now && pend_v;
   assign use_req  = req && (!active || (end_now && !pend_v));
   assign launch   = use_pend || use_req;
   assign s_idx    = use_pend ? pend_idx  : req_idx;
   assign s_addr   = use_pend ? pend_addr : req_addr;
   assign s_rd     = use_pend ? pend_rd   : req_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur     <= '0;
         rep_cnt <= '0;
         rd_mode <= 1'b0;
         lp_idx  <= '0;
         lp_cnt  <= '0;
      end else if (launch) begin
         active  <= 1'b1;
         cur     <= s_idx;
         rep_cnt <= '0;
         rd_mode <= s_rd;
         lp_idx  <= s_idx;
         lp_cnt  <= loop_count;
      end else if (end_now) begin
         active  <= 1'b0;
         rep_cnt <= '0;
      end else if (active) begin
         if (w_ls) lp_idx <= cur;
         if (!last_rep) begin
            rep_cnt <= rep_cnt + 1'b1;
         end else begin
            rep_cnt <= '0;
            if (w_le && lp_cnt != '0) begin
               cur    <= lp_idx;
               lp_cnt <= lp_cnt - 1'b1;
            end else begin
               cur <= cur + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_addr <= '0;
         pend_rd   <= 1'b0;
      end else if (use_pend) begin
         pend_v <= 1'b0;
      end else if (req && active && !pend_v && !use_req) begin
         pend_v    <= 1'b1;
         pend_idx  <= req_idx;
         pend_addr <= req_addr;
         pend_rd   <= req_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err <= 1'b0;
      else if (active && w_end && w_rep != 2'd0) err <= 1'b1;
   end

   bus_seq_addr #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(launch), .ld_val(s_addr),
      .inc(active && w_step), .q(bus_addr));

   bus_seq_sample #(.DW(DW), .HALF_EN(HALF_EN)) u_samp (
      .clk(clk), .rst_n(rst_n), .cap(active && rd_mode && w_ack),
      .dly(mode_dly && w_half), .d(data_in), .q(data_q));

   assign bus_lines = active ? word[F_LINES +: LINES] : '1;
   assign xfer_ack  = active && w_ack;
   assign busy      = active;

   assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last_rep && !launch) |=> bus_lines == $past(bus_lines));
   assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (end_now && !launch) |=> (bus_lines == '1 && !xfer_ack && !busy));
   assert_chain_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

// File: tb/sim_bus_pattern_seq.sv
module sim_bus_pattern_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [5:0]  req_idx = '0;
   logic [15:0] req_addr = '0;
   logic        req_rd = 1'b0;
   logic [3:0]  loop_count = '0;
   logic        mode_dly = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [13:0] wr_word = '0;
   logic [15:0] data_in = '0;
   logic [5:0]  bus_lines;
   logic        xfer_ack, busy, err;
   logic [15:0] bus_addr, data_q;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bus_pattern_seq u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_idx(req_idx), .req_addr(req_addr),
      .req_rd(req_rd), .loop_count(loop_count), .mode_dly(mode_dly),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .data_in(data_in),
      .bus_lines(bus_lines), .xfer_ack(xfer_ack), .bus_addr(bus_addr),
      .data_q(data_q), .busy(busy), .err(err));

   function automatic logic [13:0] mk(input logic [5:0] ln, input logic fin,
      input logic ack, input logic stp, input logic hf, input logic [1:0] rp,
      input logic ls, input logic le);
      return {ln, le, ls, rp, hf, stp, ack, fin};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic wr(input int idx, input logic [13:0] w);
      wr_en = 1'b1; wr_idx = 6'(idx); wr_word = w; cyc(); wr_en = 1'b0;
   endtask

   task automatic go(input int idx, input logic [15:0] a, input logic rd);
      req = 1'b1; req_idx = 6'(idx); req_addr = a; req_rd = rd; cyc(); req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 lines", bus_lines, 6'h3F);
      chk("R1 ack", xfer_ack, 0);
      chk("R1 busy", busy, 0);
      chk("R1 err", err, 0);
      chk("R1 addr", bus_addr, 0);
      chk("R1 data", data_q, 0);
   endtask

   task automatic t_repeat();
      go(0, 16'h0010, 1'b0);
      chk("R2 busy", busy, 1);
      chk("R2 addr", bus_addr, 16'h10);
      for (int i = 0; i < 3; i++) begin
         chk("R4 lines", bus_lines, 6'h2A);
         chk("R4 ack", xfer_ack, 1);
         chk("R5 addr", bus_addr, 16'h10 + i);
         cyc();
      end
      chk("R3 lines", bus_lines, 6'h15);
      chk("R4 ack off", xfer_ack, 0);
      chk("R5 addr", bus_addr, 16'h13);
      cyc();
      chk("R7 lines", bus_lines, 6'h3F);
      chk("R7 ack", xfer_ack, 0);
      chk("R7 busy", busy, 0);
   endtask

   task automatic t_loop();
      logic [5:0] exp_l [7] = '{6'h01, 6'h02, 6'h01, 6'h02, 6'h01, 6'h02, 6'h04};
      loop_count = 4'd2;
      go(8, 16'h0000, 1'b0);
      for (int i = 0; i < 7; i++) begin
         chk("R6 lines", bus_lines, exp_l[i]);
         cyc();
      end
      chk("R6 end", bus_lines, 6'h3F);
      chk("R6 addr", bus_addr, 16'h3);
      loop_count = 4'd0;
   endtask

   task automatic t_chain();
      go(20, 16'h0005, 1'b0);
      chk("R8 first", bus_lines, 6'h0A);
      req = 1'b1; req_idx = 6'd16; req_addr = 16'h0040; cyc();
      chk("R8 second", bus_lines, 6'h0B);
      req_idx = 6'd8; req_addr = 16'h0077; cyc();
      req = 1'b0;
      chk("R8 queued lines", bus_lines, 6'h05);
      chk("R8 queued addr", bus_addr, 16'h40);
      chk("R8 no gap", busy, 1);
      cyc();
      chk("R8 dropped", bus_lines, 6'h3F);
      chk("R8 dropped busy", busy, 0);
      go(16, 16'h0001, 1'b0);
      chk("R8 single", bus_lines, 6'h05);
      req = 1'b1; req_idx = 6'd20; req_addr = 16'h0050; cyc();
      req = 1'b0;
      chk("R8 direct lines", bus_lines, 6'h0A);
      chk("R8 direct addr", bus_addr, 16'h50);
      cyc();
      chk("R8 direct second", bus_lines, 6'h0B);
      cyc();
      chk("R8 idle", busy, 0);
   endtask

   task automatic t_lock();
      go(20, 16'h0000, 1'b0);
      wr_en = 1'b1; wr_idx = 6'd21; wr_word = mk(6'h3C, 1, 0, 0, 0, 0, 0, 0); cyc();
      wr_en = 1'b0;
      chk("R12 locked", bus_lines, 6'h0B);
      cyc();
      go(20, 16'h0000, 1'b0);
      cyc();
      chk("R12 locked rerun", bus_lines, 6'h0B);
      cyc();
      wr(16, mk(6'h0C, 1, 0, 0, 0, 0, 0, 0));
      go(16, 16'h0000, 1'b0);
      chk("R12 idle write", bus_lines, 6'h0C);
      cyc();
   endtask

   task automatic t_sample(input int idx, input logic md, input logic [15:0] exp, input string tag);
      mode_dly = md;
      go(idx, 16'h0000, 1'b1);
      data_in = 16'h1111;
      #3 data_in = 16'h2222;
      cyc();
      chk(tag, data_q, exp);
      cyc();
      mode_dly = 1'b0;
   endtask

   task automatic t_err();
      go(24, 16'h0000, 1'b0);
      chk("R9 lines", bus_lines, 6'h07);
      cyc();
      chk("R9 once", busy, 0);
      chk("R9 err", err, 1);
      cyc(); cyc();
      chk("R9 sticky", err, 1);
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3;
      t_reset();
      #20 rst_n = 1'b1;
      cyc();
      t_reset();
      wr(0,  mk(6'h2A, 0, 1, 1, 0, 2, 0, 0));
      wr(1,  mk(6'h15, 1, 0, 0, 0, 0, 0, 0));
      wr(8,  mk(6'h01, 0, 0, 1, 0, 0, 1, 0));
      wr(9,  mk(6'h02, 0, 0, 0, 0, 0, 0, 1));
      wr(10, mk(6'h04, 1, 0, 0, 0, 0, 0, 0));
      wr(16, mk(6'h05, 1, 0, 0, 0, 0, 0, 0));
      wr(20, mk(6'h0A, 0, 0, 0, 0, 0, 0, 0));
      wr(21, mk(6'h0B, 1, 0, 0, 0, 0, 0, 0));
      wr(24, mk(6'h07, 1, 0, 0, 0, 3, 0, 0));
      wr(28, mk(6'h09, 1, 1, 0, 1, 0, 0, 0));
      wr(30, mk(6'h0D, 1, 1, 0, 0, 0, 0, 0));
      t_repeat();
      t_loop();
      t_chain();
      t_lock();
      t_sample(28, 1'b0, 16'h2222, "R10 rise no mode");
      t_sample(28, 1'b1, 16'h1111, "R11 mid-cycle");
      t_sample(30, 1'b1, 16'h2222, "R10 rise no bit");
      t_err();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule